// File: doc/BRIEF.md
# SDRAM Bank State Checker

This block watches the command pins of an SDRAM device and keeps its own copy of each bank's state. A bank is either idle or active with one row open. The block also tracks the timing windows that follow a precharge, an auto-precharge and a mode-register load. Any command that the current state forbids is rejected and reported. A rejected command leaves the tracked state unchanged.

The block is placed beside a memory controller or a device model, in simulation or in silicon. It taps the same chip-select, row strobe, column strobe, write enable, bank and address lines that reach the memory. For every bank it presents whether the bank is open and which row is open. It raises a one-cycle violation flag, together with a code that classifies the fault. Four parameters set the timing: the precharge recovery time, the mode-load recovery time, the burst length, and whether full-page bursts are in use.

Top module: `sdram_bank_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released, all banks read as closed, every `bank_row` slice is zero and `viol` is low with `viol_code` 0.
- R2: A command is judged at the clock edge that samples it. The verdict is shown during the following cycle: `viol` is high for that cycle and `viol_code` is 1 (read/write to an idle bank), 2 (activate on an open bank), 3 (timing breach) or 4 (mode load with a bank open). The mode-load window is checked first, then the per-command rules. A rejected command changes no bank state.
- R3: `cs_n`=1 is inhibit. With `cs_n`=0, {`ras_n`,`cas_n`,`we_n`} selects the command: 011 activate, 101 read, 100 write, 010 precharge, 000 mode load, 111 NOP. Inhibit, NOP, 001 and 110 never flag a violation and leave all bank state unchanged.
- R4: An activate to an idle, recovered bank opens it, starting in the next cycle, with row `addr[10:0]`. That row is shown in `bank_row[b*11 +: 11]` until the bank closes. A closed bank's slice reads zero.
- R5: An activate to a bank that is already open gives code 2, and the open row is kept.
- R6: A read or write to an idle, recovered bank gives code 1.
- R7: A precharge with `addr[10]`=1 closes every open bank and ignores `ba`. With `addr[10]`=0 it closes only bank `ba`. Precharging an idle bank is legal and has no effect. A precharge is flagged only inside the mode-load window.
- R8: A bank closed at the edge of cycle m rejects activate, read and write with code 3 until cycle m+T_RP, when it accepts them again. A mode load while any bank is still recovering gives code 3.
- R9: A read or write with `addr[10]`=1 in cycle n schedules an auto-precharge. The bank stays open through cycle n+BURST_LEN and is closed from cycle n+BURST_LEN+1. Its recovery then runs as if an explicit precharge had been issued in cycle n+BURST_LEN. The request applies to that one command only.
- R10: A read or write to a bank whose auto-precharge is still pending gives code 3.
- R11: With FULL_PAGE set, `addr[10]` on a read or write is ignored, and the row stays open until it is precharged explicitly.
- R12: A mode load with any bank open gives code 4. A mode load is accepted when all banks are idle and recovered.
- R13: After a mode load accepted in cycle n, any activate, read, write, precharge or mode load in cycles n+1 to n+T_MRD-1 gives code 3. Such commands are accepted again from cycle n+T_MRD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low; high means inhibit |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 11 | Row address, or column in bits 7:0 with the control bit in bit 10 |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| bank_row | output | 44 | Open row of each bank, 11 bits per bank |
| viol | output | 1 | High for one cycle after a rejected command |
| viol_code | output | 3 | Class of the rejected command, 0 when none |

## Verification
The assertions cover the rules that hold on every cycle. A bank opens only after an activate. A bank-wide precharge leaves no bank open unless that precharge was rejected. Reads and writes to closed banks, activates to open banks and mode loads with a bank open are always flagged. NOP and inhibit never raise a flag. The exact cycle counts of the recovery windows, the closing cycle of an auto-precharge, the full-page exception and the code returned when several rules compete all depend on history. Only the bench's scripted sequences, with their known cycle numbers, can show those.

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard #(
  parameter int BANKS     = 4,
  parameter int ROW_W     = 11,
  parameter int AP_BIT    = 10,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [$clog2(BANKS)-1:0]   ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [BANKS-1:0]           bank_open,
  output logic [BANKS*ROW_W-1:0]     bank_row,
  output logic                       viol,
  output logic [2:0]                 viol_code
);

  localparam int RP_W  = $clog2(T_RP + 1);
  localparam int MRD_W = $clog2(T_MRD + 1);
  localparam int BL_W  = $clog2(BURST_LEN + 1);

  localparam logic [2:0] C_OK      = 3'd0;
  localparam logic [2:0] C_IDLE    = 3'd1;
  localparam logic [2:0] C_REOPEN  = 3'd2;
  localparam logic [2:0] C_TIMING  = 3'd3;
  localparam logic [2:0] C_MODEBSY = 3'd4;

  logic [ROW_W-1:0] row_q  [BANKS];
  logic [RP_W-1:0]  rp_cnt [BANKS];
  logic [BL_W-1:0]  ap_cnt [BANKS];
  logic [MRD_W-1:0] mrd_cnt;

  wire [2:0] pins = {ras_n, cas_n, we_n};
  wire is_act = !cs_n && pins == 3'b011;
  wire is_rd  = !cs_n && pins == 3'b101;
  wire is_wr  = !cs_n && pins == 3'b100;
  wire is_pre = !cs_n && pins == 3'b010;
  wire is_lmr = !cs_n && pins == 3'b000;
  wire exec   = is_act | is_rd | is_wr | is_pre | is_lmr;

  logic [BANKS-1:0] hit, rp_busy, ap_busy, close_now;
  logic             tgt_open, tgt_rp, tgt_ap;
  logic [2:0]       code_d;
  logic             accept;

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      hit[b]     = int'(ba) == b;
      rp_busy[b] = rp_cnt[b] != '0;
      ap_busy[b] = ap_cnt[b] != '0;
    end
  end

  assign tgt_open = |(bank_open & hit);
  assign tgt_rp   = |(rp_busy & hit);
  assign tgt_ap   = |(ap_busy & hit);

  always_comb begin
    code_d = C_OK;
    if (exec && mrd_cnt != '0)
      code_d = C_TIMING;
    else if (is_lmr)
      code_d = (|bank_open) ? C_MODEBSY : (|rp_busy) ? C_TIMING : C_OK;
    else if (is_act)
      code_d = tgt_rp ? C_TIMING : tgt_open ? C_REOPEN : C_OK;
    else if (is_rd || is_wr)
      code_d = tgt_rp ? C_TIMING : !tgt_open ? C_IDLE : tgt_ap ? C_TIMING : C_OK;
  end

  assign accept = exec && code_d == C_OK;

  always_comb begin
    for (int b = 0; b < BANKS; b++)
      close_now[b] = bank_open[b] &&
                     ((accept && is_pre && (addr[AP_BIT] || hit[b])) ||
                      ap_cnt[b] == BL_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        bank_open[b] <= 1'b0;
        row_q[b]     <= '0;
        rp_cnt[b]    <= '0;
        ap_cnt[b]    <= '0;
      end
      mrd_cnt   <= '0;
      viol      <= 1'b0;
      viol_code <= C_OK;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (close_now[b]) begin
          bank_open[b] <= 1'b0;
          row_q[b]     <= '0;
          rp_cnt[b]    <= RP_W'(T_RP - 1);
          ap_cnt[b]    <= '0;
        end else begin
          if (rp_busy[b]) rp_cnt[b] <= rp_cnt[b] - RP_W'(1);
          if (ap_busy[b]) ap_cnt[b] <= ap_cnt[b] - BL_W'(1);
          if (accept && is_act && hit[b]) begin
            bank_open[b] <= 1'b1;
            row_q[b]     <= addr;
          end
          if (accept && (is_rd || is_wr) && hit[b] && addr[AP_BIT] && !FULL_PAGE)
            ap_cnt[b] <= BL_W'(BURST_LEN);
        end
      end
      if (accept && is_lmr)     mrd_cnt <= MRD_W'(T_MRD - 1);
      else if (mrd_cnt != '0)   mrd_cnt <= mrd_cnt - MRD_W'(1);
      viol      <= code_d != C_OK;
      viol_code <= code_d;
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_row
    assign bank_row[g*ROW_W +: ROW_W] = row_q[g];
  end

endmodule

// File: rtl/sdram_bank_guard_chk.sv
module sdram_bank_guard_chk #(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 11,
  parameter int AP_BIT = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cs_n,
  input logic                     ras_n,
  input logic                     cas_n,
  input logic                     we_n,
  input logic [$clog2(BANKS)-1:0] ba,
  input logic [ROW_W-1:0]         addr,
  input logic [BANKS-1:0]         bank_open,
  input logic                     viol,
  input logic [2:0]               viol_code
);
  wire [2:0] pins = {ras_n, cas_n, we_n};
  wire c_act = !cs_n && pins == 3'b011;
  wire c_acc = !cs_n && (pins == 3'b101 || pins == 3'b100);
  wire c_pre = !cs_n && pins == 3'b010;
  wire c_lmr = !cs_n && pins == 3'b000;
  wire c_idle = cs_n || pins == 3'b111;

  assert_open_needs_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !c_act |=> ((bank_open & ~$past(bank_open)) == '0));

  assert_reopen_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_act && bank_open[ba]) |=> viol);

  assert_idle_access_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && !bank_open[ba]) |=> viol);

  assert_pre_all_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && addr[AP_BIT]) |=> (bank_open == '0 || viol));

  assert_mode_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lmr && |bank_open) |=> (viol && (viol_code == 3'd4 || viol_code == 3'd3)));

  assert_quiet_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_idle |=> !viol);

  assert_flag_has_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code >= 3'd1 && viol_code <= 3'd4));
endmodule

bind sdram_bank_guard sdram_bank_guard_chk #(.BANKS(BANKS), .ROW_W(ROW_W), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .addr(addr), .bank_open(bank_open), .viol(viol), .viol_code(viol_code)
);

// File: tb/test_sdram_bank_guard.sv
module test_sdram_bank_guard;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         PRE = 3'b010, LMR = 3'b000, RF = 3'b001, BT = 3'b110;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [3:0]  open_m, open_f;
  logic [43:0] row_m, row_f;
  logic        viol_m, viol_f;
  logic [2:0]  code_m, code_f;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_bank_guard #(.T_RP(3), .T_MRD(2), .BURST_LEN(4), .FULL_PAGE(1'b0)) i_sdram_bank_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .bank_open(open_m), .bank_row(row_m), .viol(viol_m), .viol_code(code_m));

  sdram_bank_guard #(.T_RP(3), .T_MRD(2), .BURST_LEN(4), .FULL_PAGE(1'b1)) i_sdram_bank_guard_fp (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .bank_open(open_f), .bank_row(row_f), .viol(viol_f), .viol_code(code_f));

  typedef struct packed {
    logic cs; logic [2:0] cmd; logic [1:0] b; logic [10:0] a;
    logic v; logic [2:0] c; logic [3:0] o; logic [10:0] r;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, LMR, 2'd0, 11'h000, 1'b0, 3'd0, 4'b0000, 11'h000}, // 0  R12 accepted
    '{1'b0, ACT, 2'd0, 11'h005, 1'b1, 3'd3, 4'b0000, 11'h000}, // 1  R13 window
    '{1'b0, ACT, 2'd0, 11'h005, 1'b0, 3'd0, 4'b0001, 11'h005}, // 2  R13 edge, R4
    '{1'b0, ACT, 2'd0, 11'h006, 1'b1, 3'd2, 4'b0001, 11'h005}, // 3  R5 R2
    '{1'b0, RD,  2'd1, 11'h000, 1'b1, 3'd1, 4'b0001, 11'h000}, // 4  R6
    '{1'b0, WR,  2'd0, 11'h000, 1'b0, 3'd0, 4'b0001, 11'h005}, // 5  R4
    '{1'b1, ACT, 2'd1, 11'h001, 1'b0, 3'd0, 4'b0001, 11'h000}, // 6  R3 inhibit
    '{1'b0, RF,  2'd1, 11'h001, 1'b0, 3'd0, 4'b0001, 11'h000}, // 7  R3 other
    '{1'b0, LMR, 2'd0, 11'h000, 1'b1, 3'd4, 4'b0001, 11'h005}, // 8  R12
    '{1'b0, ACT, 2'd2, 11'h007, 1'b0, 3'd0, 4'b0101, 11'h007}, // 9  R4
    '{1'b0, PRE, 2'd2, 11'h000, 1'b0, 3'd0, 4'b0001, 11'h000}, // 10 R7 single
    '{1'b0, ACT, 2'd2, 11'h009, 1'b1, 3'd3, 4'b0001, 11'h000}, // 11 R8
    '{1'b0, RD,  2'd2, 11'h000, 1'b1, 3'd3, 4'b0001, 11'h000}, // 12 R8
    '{1'b0, ACT, 2'd2, 11'h009, 1'b0, 3'd0, 4'b0101, 11'h009}, // 13 R8 edge
    '{1'b0, PRE, 2'd3, 11'h400, 1'b0, 3'd0, 4'b0000, 11'h000}, // 14 R7 all
    '{1'b0, PRE, 2'd3, 11'h000, 1'b0, 3'd0, 4'b0000, 11'h000}, // 15 R7 idle
    '{1'b0, LMR, 2'd0, 11'h000, 1'b1, 3'd3, 4'b0000, 11'h000}, // 16 R8 mode
    '{1'b0, LMR, 2'd0, 11'h000, 1'b0, 3'd0, 4'b0000, 11'h000}, // 17 R12
    '{1'b0, NOP, 2'd0, 11'h000, 1'b0, 3'd0, 4'b0000, 11'h000}, // 18 R3
    '{1'b0, ACT, 2'd3, 11'h7FF, 1'b0, 3'd0, 4'b1000, 11'h7FF}, // 19 R4
    '{1'b0, RD,  2'd3, 11'h400, 1'b0, 3'd0, 4'b1000, 11'h7FF}, // 20 R9
    '{1'b0, RD,  2'd3, 11'h000, 1'b1, 3'd3, 4'b1000, 11'h7FF}, // 21 R10
    '{1'b0, NOP, 2'd3, 11'h000, 1'b0, 3'd0, 4'b1000, 11'h7FF}, // 22 R9
    '{1'b0, NOP, 2'd3, 11'h000, 1'b0, 3'd0, 4'b1000, 11'h7FF}, // 23 R9
    '{1'b0, NOP, 2'd3, 11'h000, 1'b0, 3'd0, 4'b0000, 11'h000}, // 24 R9 closed
    '{1'b0, ACT, 2'd3, 11'h003, 1'b1, 3'd3, 4'b0000, 11'h000}, // 25 R8
    '{1'b0, ACT, 2'd3, 11'h003, 1'b1, 3'd3, 4'b0000, 11'h000}, // 26 R8
    '{1'b0, ACT, 2'd3, 11'h003, 1'b0, 3'd0, 4'b1000, 11'h003}, // 27 R9 recovery
    '{1'b0, WR,  2'd3, 11'h401, 1'b0, 3'd0, 4'b1000, 11'h003}, // 28 R9
    '{1'b0, ACT, 2'd0, 11'h001, 1'b0, 3'd0, 4'b1001, 11'h001}, // 29 R4
    '{1'b0, RD,  2'd3, 11'h000, 1'b1, 3'd3, 4'b1001, 11'h003}, // 30 R10
    '{1'b0, NOP, 2'd3, 11'h000, 1'b0, 3'd0, 4'b1001, 11'h003}, // 31 R9
    '{1'b0, NOP, 2'd3, 11'h000, 1'b0, 3'd0, 4'b0001, 11'h000}  // 32 R9 closed
  };

  function automatic string tag_of(int i);
    case (i)
      0, 8, 17:                 return "R12";
      1, 2:                     return "R13";
      3:                        return "R2 R5";
      4:                        return "R6";
      6, 7, 18:                 return "R3";
      10, 14, 15:               return "R7";
      11, 12, 13, 16, 25, 26:   return "R8";
      21, 30:                   return "R10";
      20, 22, 23, 24, 27, 28, 31, 32: return "R9";
      default:                  return "R4";
    endcase
  endfunction

  task automatic drive(input logic cs, input logic [2:0] cmd, input logic [1:0] b, input logic [10:0] a);
    cs_n = cs; {ras_n, cas_n, we_n} = cmd; ba = b; addr = a;
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog got %0d expected below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {open_m, row_m, viol_m, code_m}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {open_m, row_m, viol_m, code_m}, '0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cs, VECS[i].cmd, VECS[i].b, VECS[i].a);
      @(negedge clk);
      check(tag_of(i), {viol_m, code_m, open_m, row_m[int'(VECS[i].b)*11 +: 11]},
            {VECS[i].v, VECS[i].c, VECS[i].o, VECS[i].r});
    end

    // R1 reset in the middle of activity
    drive(1'b0, NOP, 2'd0, 11'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", {open_m, row_m, viol_m, code_m}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 full-page keeps the row open; R9 contrast on the other instance
    drive(1'b0, ACT, 2'd1, 11'h123);
    @(negedge clk);
    drive(1'b0, RD, 2'd1, 11'h400);
    @(negedge clk);
    check("R11 read accepted", {viol_f, code_f}, '0);
    drive(1'b0, NOP, 2'd1, 11'h0);
    repeat (8) @(negedge clk);
    check("R11 row kept", {open_f, row_f[11 +: 11]}, {4'b0010, 11'h123});
    check("R9 row closed", open_m, 4'b0000);
    drive(1'b0, RD, 2'd1, 11'h000);
    @(negedge clk);
    check("R11 later read", {viol_f, code_f}, '0);
    drive(1'b0, BT, 2'd1, 11'h000);
    @(negedge clk);
    check("R3 burst stop ignored", {viol_f, open_f, row_f[11 +: 11]}, {1'b0, 4'b0010, 11'h123});
    drive(1'b0, PRE, 2'd1, 11'h000);
    @(negedge clk);
    check("R11 explicit close", open_f, 4'b0000);
    drive(1'b0, NOP, 2'd0, 11'h0);
    @(negedge clk);
    finish_run();
  end
endmodule